// File: doc/BRIEF.md
# Uncore Event Counter Bank

A bank of eight 64-bit event counters behind a simple register interface. Each counter is tied to one 8-bit event code and advances by one on every cycle in which the event strobe selected by that code is high, provided the counter's own enable and the bank-wide run bit are both set. The event sources arrive as a vector of one-cycle strobes, one bit per possible event code.

Software programs the codes through packed select words, starts and stops counting through a control word, and presets or reads counters as 64-bit values. A counter that rolls over from all-ones to zero raises a sticky status flag. Flags are cleared by writing ones, and each flag can be masked from the single interrupt output.

The run bit also gates the counter clock. Counter presets therefore only land while the bank is running. A preset counter keeps its value after the bank is stopped.

Top module: `evctr_bank`

## Requirements
- R1: Counter n (0..7) reads and writes as a 64-bit value at offset 0x1E00 + 8*n.
- R2: Codes for counters 0-3 are held in the 32-bit select word at 0x1D00 and codes for counters 4-7 in the word at 0x1D04. Counter n uses byte lane n%4, bits [8*(n%4)+7 : 8*(n%4)], and both words read back as written.
- R3: In the control word at 0x1C00, bit n enables counter n and bit 26 is the run bit. With both set, a counter advances by exactly one in each cycle in which ev_strobe[code] is high.
- R4: While the run bit is clear, no counter changes on events.
- R5: A counter whose own enable bit is clear does not count, even while the bank is running.
- R6: A write to a counter takes effect only if the run bit is set in the cycle of the write, and is otherwise ignored.
- R7: If a counter is written in the same cycle as one of its events arrives, the written value is kept and the event is lost.
- R8: When a counter rolls over from all-ones to zero, its bit in the status register at 0x808 is set at the same clock edge.
- R9: Writing a 1 to bit n of the clear register at 0x80C clears status bit n, and bits written as 0 leave their flags unchanged.
- R10: In the mask register at 0x800, a set bit n masks counter n. irq is high exactly when some status bit is set whose mask bit is clear.
- R11: Reset clears all counters, enables, the run bit, the select words and the status flags, and sets all eight mask bits (0xFF).
- R12: Offset 0x1CF0 reads the VERSION parameter (default 0x00010200) and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 16 | Byte offset of the register accessed |
| bus_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| ev_strobe | input | 256 | One-cycle event strobes indexed by event code |
| irq | output | 1 | Overflow interrupt, OR of unmasked status flags |

## Verification
Events are sent on codes owned by enabled counters, by disabled counters, by codes that sit in a neighbouring byte lane, and with the run bit clear. Together these separate a correct code and enable match from lane or enable decoding errors. Presets are issued with the bank stopped and then running, and also in the same cycle as an event, which shows whether the run-bit gating and the write priority are correct. A rollover from all-ones is observed while masked and then unmasked, followed by clears of a non-matching flag and then the matching flag. This shows that the status, mask and clear paths stay independent of each other.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
    localparam logic [15:0] ADDR_MASK = 16'h0800;
    localparam logic [15:0] ADDR_STS  = 16'h0808;
    localparam logic [15:0] ADDR_CLR  = 16'h080C;
    localparam logic [15:0] ADDR_CTRL = 16'h1C00;
    localparam logic [15:0] ADDR_VER  = 16'h1CF0;
    localparam logic [15:0] ADDR_SEL  = 16'h1D00;
    localparam logic [15:0] ADDR_CNT  = 16'h1E00;
    localparam int          RUN_BIT   = 26;
    localparam int          WORD_W    = 32;
endpackage

// File: rtl/evctr_regs.sv
module evctr_regs
    import evctr_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CODE_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [15:0]                       bus_addr,
    input  logic [WORD_W-1:0]                 wr_word,
    output logic [NUM_CNT-1:0]                cnt_en,
    output logic                              run_en,
    output logic [NUM_CNT-1:0]                int_mask,
    output logic [NUM_CNT-1:0]                clr_hit,
    output logic [NUM_CNT-1:0]                cnt_wr,
    output logic [(NUM_CNT+WORD_W/CODE_W-1)/(WORD_W/CODE_W)-1:0][WORD_W-1:0] sel_q,
    output logic [NUM_CNT-1:0][CODE_W-1:0]    code
);
    localparam int LANES     = WORD_W / CODE_W;
    localparam int SEL_WORDS = (NUM_CNT + LANES - 1) / LANES;

    logic wr_ctrl, wr_mask, wr_clr;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_mask = bus_wr && (bus_addr == ADDR_MASK);
    assign wr_clr  = bus_wr && (bus_addr == ADDR_CLR);
    assign clr_hit = wr_clr ? wr_word[NUM_CNT-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en   <= '0;
            run_en   <= 1'b0;
            int_mask <= '1;
        end else begin
            if (wr_ctrl) begin
                cnt_en <= wr_word[NUM_CNT-1:0];
                run_en <= wr_word[RUN_BIT];
            end
            if (wr_mask) int_mask <= wr_word[NUM_CNT-1:0];
        end
    end

    for (genvar w = 0; w < SEL_WORDS; w++) begin : g_sel
        logic hit;
        assign hit = bus_wr && (bus_addr == ADDR_SEL + 16'(4 * w));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sel_q[w] <= '0;
            else if (hit) sel_q[w] <= wr_word;
        end
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_dec
        // the clock of the counters is gated by the run bit: writes need it set
        assign cnt_wr[n] = bus_wr && run_en && (bus_addr == ADDR_CNT + 16'(8 * n));
        assign code[n]   = sel_q[n / LANES][(n % LANES) * CODE_W +: CODE_W];
    end
endmodule

// File: rtl/evctr_counter.sv
module evctr_counter #(
    parameter int CNT_W  = 64,
    parameter int CODE_W = 8,
    parameter int EV_W   = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    input  logic [EV_W-1:0]   ev_strobe,
    input  logic              wr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    logic hit;

    assign hit  = en && run && ev_strobe[code];
    assign wrap = hit && !wr && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (wr)  count <= wdata;
        else if (hit) count <= count + 1'b1;
    end
endmodule

// File: rtl/evctr_irq.sv
module evctr_irq #(
    parameter int NUM_CNT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] wrap,
    input  logic [NUM_CNT-1:0] clr,
    input  logic [NUM_CNT-1:0] mask,
    output logic [NUM_CNT-1:0] sts,
    output logic               irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~clr) | wrap;
    end

    assign irq = |(sts & ~mask);
endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int          NUM_CNT = 8,
    parameter int          CNT_W   = 64,
    parameter int          CODE_W  = 8,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [15:0]            bus_addr,
    input  logic [CNT_W-1:0]       bus_wdata,
    output logic [CNT_W-1:0]       bus_rdata,
    input  logic [(1<<CODE_W)-1:0] ev_strobe,
    output logic                   irq
);
    localparam int EV_W      = 1 << CODE_W;
    localparam int LANES     = WORD_W / CODE_W;
    localparam int SEL_WORDS = (NUM_CNT + LANES - 1) / LANES;

    logic [NUM_CNT-1:0]                 cnt_en, int_mask, clr_hit, cnt_wr, wrap, sts;
    logic                               run_en;
    logic [SEL_WORDS-1:0][WORD_W-1:0]   sel_q;
    logic [NUM_CNT-1:0][CODE_W-1:0]     code;
    logic [NUM_CNT-1:0][CNT_W-1:0]      cnt_q;

    evctr_regs #(.NUM_CNT(NUM_CNT), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .wr_word(bus_wdata[WORD_W-1:0]), .cnt_en(cnt_en), .run_en(run_en),
        .int_mask(int_mask), .clr_hit(clr_hit), .cnt_wr(cnt_wr),
        .sel_q(sel_q), .code(code)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evctr_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .EV_W(EV_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .en(cnt_en[n]), .run(run_en),
            .code(code[n]), .ev_strobe(ev_strobe), .wr(cnt_wr[n]),
            .wdata(bus_wdata), .count(cnt_q[n]), .wrap(wrap[n])
        );
    end

    evctr_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .clr(clr_hit),
        .mask(int_mask), .sts(sts), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_MASK: bus_rdata[NUM_CNT-1:0] = int_mask;
            ADDR_STS:  bus_rdata[NUM_CNT-1:0] = sts;
            ADDR_CTRL: begin
                bus_rdata[NUM_CNT-1:0] = cnt_en;
                bus_rdata[RUN_BIT]     = run_en;
            end
            ADDR_VER:  bus_rdata[WORD_W-1:0] = VERSION;
            default:   ;
        endcase
        for (int w = 0; w < SEL_WORDS; w++)
            if (bus_addr == ADDR_SEL + 16'(4 * w)) bus_rdata[WORD_W-1:0] = sel_q[w];
        for (int n = 0; n < NUM_CNT; n++)
            if (bus_addr == ADDR_CNT + 16'(8 * n)) bus_rdata = cnt_q[n];
    end
endmodule

// File: rtl/evctr_bank_chk.sv
module evctr_bank_chk #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          run_en,
    input logic [NUM_CNT-1:0]            cnt_wr,
    input logic [CNT_W-1:0]              bus_wdata,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_CNT-1:0]            sts,
    input logic [NUM_CNT-1:0]            int_mask,
    input logic                          irq
);
    assert_reset_state_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (int_mask == '1 && sts == '0 && cnt_q == '0));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == '1) |-> !irq);

    assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != '0));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_wr[i] |=> (cnt_q[i] == $past(cnt_q[i]) || cnt_q[i] == $past(cnt_q[i]) + 1'b1));

        assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_en && !cnt_wr[i]) |=> $stable(cnt_q[i]));

        assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wr[i] |=> (cnt_q[i] == $past(bus_wdata)));

        assert_wrap_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == '0 && $past(cnt_q[i] == {CNT_W{1'b1}} && !cnt_wr[i])) |-> sts[i]);
    end
endmodule

bind evctr_bank evctr_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_wr(cnt_wr),
    .bus_wdata(bus_wdata), .cnt_q(cnt_q), .sts(sts), .int_mask(int_mask), .irq(irq)
);

// File: tb/test_evctr_bank.sv
module test_evctr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [255:0] ev_strobe = '0;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    evctr_bank i_evctr_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_strobe(ev_strobe), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read and compare, 2 event pulse
        logic [15:0] addr;
        logic [63:0] data;
        logic        irq;
    } vec_t;

    localparam int NV = 41;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h1D00, 64'h0503_0201, 1'b0},   // R2 codes 01,02,03,05
        '{2'd0, 16'h1D04, 64'h1110_0706, 1'b0},   // R2 codes 06,07,10,11
        '{2'd1, 16'h1D00, 64'h0503_0201, 1'b0},   // R2
        '{2'd1, 16'h1D04, 64'h1110_0706, 1'b0},   // R2
        '{2'd0, 16'h1E00, 64'd5,         1'b0},   // R6 stopped: ignored
        '{2'd1, 16'h1E00, 64'd0,         1'b0},   // R6
        '{2'd0, 16'h1C00, 64'h0400_0003, 1'b0},   // R3 run + cnt0,cnt1
        '{2'd1, 16'h1C00, 64'h0400_0003, 1'b0},   // R3
        '{2'd0, 16'h1E00, 64'd5,         1'b0},   // R6 running: lands
        '{2'd1, 16'h1E00, 64'd5,         1'b0},   // R6, R1
        '{2'd2, 16'h0000, 64'h01,        1'b0},   // R3
        '{2'd2, 16'h0000, 64'h02,        1'b0},   // R3
        '{2'd2, 16'h0000, 64'h06,        1'b0},   // R5 cnt4 disabled
        '{2'd1, 16'h1E00, 64'd6,         1'b0},   // R3
        '{2'd1, 16'h1E08, 64'd1,         1'b0},   // R3
        '{2'd1, 16'h1E20, 64'd0,         1'b0},   // R5
        '{2'd0, 16'h1E08, ONES,          1'b0},   // R1
        '{2'd1, 16'h1E08, ONES,          1'b0},   // R1
        '{2'd2, 16'h0000, 64'h02,        1'b0},   // R8 rollover
        '{2'd1, 16'h1E08, 64'd0,         1'b0},   // R8
        '{2'd1, 16'h0808, 64'h02,        1'b0},   // R8, R10 masked
        '{2'd0, 16'h0800, 64'hFD,        1'b0},   // R10 unmask cnt1
        '{2'd1, 16'h0800, 64'hFD,        1'b1},   // R10
        '{2'd0, 16'h080C, 64'h01,        1'b0},   // R9 other bit
        '{2'd1, 16'h0808, 64'h02,        1'b1},   // R9
        '{2'd0, 16'h080C, 64'h02,        1'b0},   // R9
        '{2'd1, 16'h0808, 64'h00,        1'b0},   // R9
        '{2'd0, 16'h1C00, 64'h0000_0003, 1'b0},   // R4 stop
        '{2'd2, 16'h0000, 64'h01,        1'b0},   // R4
        '{2'd1, 16'h1E00, 64'd6,         1'b0},   // R4
        '{2'd0, 16'h1C00, 64'h0400_0040, 1'b0},   // R2 run + cnt6 only
        '{2'd2, 16'h0000, 64'h10,        1'b0},   // R2 lane 2 of word 1
        '{2'd2, 16'h0000, 64'h07,        1'b0},   // R2 neighbour lane
        '{2'd2, 16'h0000, 64'h01,        1'b0},   // R5
        '{2'd1, 16'h1E30, 64'd1,         1'b0},   // R2
        '{2'd1, 16'h1E00, 64'd6,         1'b0},   // R5
        '{2'd2, 16'h0000, 64'h10,        1'b0},   // R3
        '{2'd2, 16'h0000, 64'h10,        1'b0},   // R3
        '{2'd1, 16'h1E30, 64'd3,         1'b0},   // R3
        '{2'd0, 16'h1CF0, 64'hFFFF_FFFF, 1'b0},   // R12 write ignored
        '{2'd1, 16'h1CF0, 64'h0001_0200, 1'b0}    // R12
    };

    task automatic do_write(input logic [15:0] a, input logic [63:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_event(input logic [7:0] c);
        ev_strobe[c] = 1'b1;
        @(negedge clk);
        ev_strobe = '0;
    endtask

    task automatic do_check(input string req, input logic [15:0] a,
                            input logic [63:0] d, input logic ei);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== d || irq !== ei) begin
            n_fail++;
            $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, a, bus_rdata, irq, d, ei);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        do_check("R11", 16'h0800, 64'hFF, 1'b0);
        do_check("R11", 16'h0808, 64'h00, 1'b0);
        do_check("R11", 16'h1C00, 64'h00, 1'b0);
        do_check("R11", 16'h1E38, 64'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                2'd0: do_write(VECS[i].addr, VECS[i].data);
                2'd1: do_check("table", VECS[i].addr, VECS[i].data, VECS[i].irq);
                default: do_event(VECS[i].data[7:0]);
            endcase
        end

        // R7: preset and event in the same cycle on cnt6 (code 0x10, running)
        bus_wr = 1'b1; bus_addr = 16'h1E30; bus_wdata = 64'd100;
        ev_strobe[8'h10] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_strobe = '0;
        do_check("R7", 16'h1E30, 64'd100, 1'b0);

        // R8 + R10: unmasked rollover raises irq at once
        do_write(16'h0800, 64'hBF);
        do_write(16'h1E30, ONES);
        do_event(8'h10);
        do_check("R8", 16'h0808, 64'h40, 1'b1);

        // R11: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_check("R11", 16'h0808, 64'h00, 1'b0);
        do_check("R11", 16'h0800, 64'hFF, 1'b0);
        do_check("R11", 16'h1E30, 64'h00, 1'b0);
        do_check("R11", 16'h1D04, 64'h00, 1'b0);
        do_check("R11", 16'h1C00, 64'h00, 1'b0);
        finish_run();
    end
endmodule